// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor

This block is a small 32-bit processor core that completes one instruction on every rising clock edge. It supports nine instructions: word load, word store, add, subtract, and, or, set-less-than, branch-if-equal and an absolute jump. Its parts are a program counter, a 32-entry register file, an ALU and its operation decoder, a main control decoder, and the logic that forms branch and jump targets. Program and data live in two separate word-addressed arrays.

Before reset is released, a testbench or boot agent uses one shared load port to fill the arrays. A select bit chooses the program array or the data array. Once running, the core shows every cycle's architectural effect on its observation ports: the current PC and instruction word, any register write-back, and any store. The commit of the instruction at `pc_o` is visible during that cycle and takes effect at the next rising edge.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset forces the PC to 0. After reset, every instruction that is neither a taken branch nor a jump advances the PC by 4.
- R2: Opcode 0 is register-to-register. Fields are opcode [31:26], first source [25:21], second source [20:16], destination [15:11] and function [5:0]. Function 0x20 adds, 0x22 subtracts (first minus second), 0x24 ANDs and 0x25 ORs. The result is written to the destination register.
- R3: Function 0x2A writes 1 when the first source is less than the second as signed 32-bit values, and 0 otherwise.
- R4: Opcode 35 (load) reads the data word at index address[9:2] and writes it to register [20:16]. The address is the first source plus the sign-extended [15:0].
- R5: Opcode 43 (store) writes register [20:16] to the data word at the same kind of address. A store makes no register write.
- R6: Opcode 4 (branch) subtracts the two sources and branches when the result is zero. The taken target is PC+4 plus the sign-extended [15:0] shifted left by 2. Otherwise the PC advances by 4. A branch makes no register write.
- R7: Opcode 2 (jump) sets the PC to PC[31:28], then bits [25:0], then two zero bits. A jump makes no register write.
- R8: Register 0 always reads as zero. A write that targets it has no effect.
- R9: Any other opcode, and any register-to-register function code not listed above, advances the PC by 4 and writes neither a register nor memory.
- R10: When `ld_we` is high, the load port writes `ld_data` at word index `ld_addr`. It writes the data array when `ld_dmem` is 1 and the program array when it is 0. The core then fetches the word from the array index PC[9:2].
- R11: Reset clears all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 1 data array, 0 program array |
| ld_addr | input | MEM_AW | Load-port word index |
| ld_data | input | 32 | Load-port write word |
| pc_o | output | 32 | Current program counter |
| ir_o | output | 32 | Instruction fetched at `pc_o` |
| rf_we_o | output | 1 | Register write-back this cycle |
| rf_waddr_o | output | 5 | Write-back register number |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Store this cycle |
| dm_addr_o | output | 32 | Load/store byte address (ALU result) |
| dm_wdata_o | output | 32 | Store data |

## Verification
The bench builds the core with the default 8-bit word index, which gives 256-word arrays. This lets one short program hold the instruction mix and every data word it needs. At that size, negative load and store offsets and both forward and backward control flow fit in the first few dozen words. These include a not-taken branch, a taken forward branch, a countdown loop closed by a jump, and a branch to itself as a halt. The preloaded data includes the extreme signed values, so set-less-than is exercised across the sign boundary.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_JUMP  = 6'd2;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'd0,
    AOP_SUB   = 2'd1,
    AOP_FUNCT = 2'd2
  } aluop_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alufn_e;

  typedef struct packed {
    logic   dst_rd;
    logic   use_imm;
    logic   wb_mem;
    logic   reg_write;
    logic   mem_write;
    logic   branch;
    logic   jump;
    aluop_e aluop;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{dst_rd: 1'b0, use_imm: 1'b0, wb_mem: 1'b0, reg_write: 1'b0,
             mem_write: 1'b0, branch: 1'b0, jump: 1'b0, aluop: AOP_ADD};
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd    = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.aluop     = AOP_FUNCT;
      end
      OP_LOAD: begin
        ctrl.use_imm   = 1'b1;
        ctrl.wb_mem    = 1'b1;
        ctrl.reg_write = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluop  = AOP_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  aluop_e       aluop,
  input  logic [5:0]   funct,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         fn_ok
);
  alufn_e fn;

  always_comb begin
    fn    = ALU_ADD;
    fn_ok = 1'b1;
    unique case (aluop)
      AOP_SUB:   fn = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_ADD:  fn = ALU_ADD;
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn_ok = 1'b0;
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                    regs[i] <= '0;
      else if (we && wa == AW'(i)) regs[i] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int AW = 8,
  parameter int W  = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       pc_o,
  output logic [31:0]       ir_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [31:0]       rf_wdata_o,
  output logic              dm_we_o,
  output logic [31:0]       dm_addr_o,
  output logic [31:0]       dm_wdata_o
);
  localparam int NREG = 1 << RAW;

  logic [XLEN-1:0] pc, pc_plus4, br_tgt, j_tgt, pc_next;
  logic [XLEN-1:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_y, dm_rdata;
  logic            alu_zero, fn_ok, rf_we, dm_we_mem;
  logic [RAW-1:0]  waddr;
  logic [XLEN-1:0] wdata;
  logic [MEM_AW-1:0] dm_widx;
  logic [XLEN-1:0] dm_wd_mem;
  ctrl_t           ctrl;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  sc_wordmem #(.AW(MEM_AW), .W(XLEN)) u_imem (
    .clk(clk), .we(ld_we && !ld_dmem), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc[MEM_AW+1:2]), .rdata(instr)
  );

  sc_decoder u_dec (.opcode(instr[31:26]), .ctrl(ctrl));

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(instr[25:21]), .ra2(instr[20:16]), .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(waddr), .wd(wdata)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .aluop(ctrl.aluop), .funct(instr[5:0]), .a(rs_val), .b(alu_b),
    .y(alu_y), .zero(alu_zero), .fn_ok(fn_ok)
  );

  // Load port takes the data array's single write port when it targets it.
  assign dm_we_mem = (ld_we && ld_dmem) || ctrl.mem_write;
  assign dm_widx   = (ld_we && ld_dmem) ? ld_addr : alu_y[MEM_AW+1:2];
  assign dm_wd_mem = (ld_we && ld_dmem) ? ld_data : rt_val;

  sc_wordmem #(.AW(MEM_AW), .W(XLEN)) u_dmem (
    .clk(clk), .we(dm_we_mem), .waddr(dm_widx), .wdata(dm_wd_mem),
    .raddr(alu_y[MEM_AW+1:2]), .rdata(dm_rdata)
  );

  assign rf_we = ctrl.reg_write && (ctrl.aluop != AOP_FUNCT || fn_ok);
  assign waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign wdata = ctrl.wb_mem ? dm_rdata : alu_y;

  assign pc_plus4 = pc + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign j_tgt    = {pc[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                  pc_next = j_tgt;
    else if (ctrl.branch && alu_zero) pc_next = br_tgt;
    else                            pc_next = pc_plus4;
  end

  assign pc_o       = pc;
  assign ir_o       = instr;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wdata;
  assign dm_we_o    = ctrl.mem_write;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] ir,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        dm_we,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);
  logic [5:0] op;
  logic       known_op;
  assign op       = ir[31:26];
  assign known_op = (op == 6'd0) || (op == 6'd35) || (op == 6'd43) ||
                    (op == 6'd4) || (op == 6'd2);

  // R1
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  // R2
  rtype_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd0 && rf_we) |-> rf_waddr == ir[15:11]);

  // R5
  store_noreg_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we);

  // R6
  beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

  // R7
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00});

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (ir[25:21] == 5'd0) |-> rs_val == 32'd0);

  // R9
  unknown_nop_chk: assert property (@(posedge clk) disable iff (rst)
    !known_op |-> (!rf_we && !dm_we));

  // R9
  unknown_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !known_op |=> pc == $past(pc) + 32'd4);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc_o), .ir(ir_o), .rf_we(rf_we_o),
  .rf_waddr(rf_waddr_o), .dm_we(dm_we_o), .rs_val(rs_val), .rt_val(rt_val)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int MEM_AW = 8;
  localparam int DEPTH  = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0, ld_dmem = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, ir_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic rf_we_o, dm_we_o;
  logic [4:0] rf_waddr_o;

  always #4 clk = ~clk;

  sc_core #(.MEM_AW(MEM_AW)) u0 (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .ir_o(ir_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
    .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] imem_m [DEPTH];
  logic [31:0] dmem_m [DEPTH];
  logic [31:0] regs_m [32];
  logic [31:0] pc_m;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rt_i(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] jt_i(input int word);
    return {6'd2, 26'(word)};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin : main
    string prev_tag;
    for (int i = 0; i < DEPTH; i++) begin imem_m[i] = '0; dmem_m[i] = '0; end
    for (int i = 0; i < 32; i++) regs_m[i] = '0;
    dmem_m[0] = 32'd5;        dmem_m[1] = 32'hFFFF_FFFD;
    dmem_m[2] = 32'h0F0F_00FF; dmem_m[3] = 32'h7FFF_FFFF;
    dmem_m[4] = 32'h8000_0000; dmem_m[5] = 32'd3; dmem_m[6] = 32'd1;

    imem_m[0]  = rt_i(2, 3, 1, 6'h20);        // add r1 = 0 (reset state)
    imem_m[1]  = it_i(6'd35, 0, 2, 0);        // lw r2 = 5
    imem_m[2]  = it_i(6'd35, 0, 3, 4);        // lw r3 = -3
    imem_m[3]  = it_i(6'd35, 0, 4, 8);        // lw r4
    imem_m[4]  = rt_i(2, 3, 5, 6'h20);        // add
    imem_m[5]  = rt_i(2, 3, 6, 6'h22);        // sub -> 8
    imem_m[6]  = rt_i(4, 3, 7, 6'h24);        // and
    imem_m[7]  = rt_i(4, 2, 8, 6'h25);        // or
    imem_m[8]  = rt_i(3, 2, 9, 6'h2A);        // slt -> 1
    imem_m[9]  = rt_i(2, 3, 10, 6'h2A);       // slt -> 0
    imem_m[10] = it_i(6'd35, 0, 11, 12);
    imem_m[11] = it_i(6'd35, 0, 12, 16);
    imem_m[12] = rt_i(12, 11, 13, 6'h2A);     // min < max -> 1
    imem_m[13] = rt_i(2, 2, 0, 6'h20);        // write to r0 ignored
    imem_m[14] = it_i(6'd43, 0, 0, 32);       // sw r0
    imem_m[15] = it_i(6'd43, 6, 5, 32);       // sw r5 -> addr 40
    imem_m[16] = it_i(6'd35, 0, 14, 40);      // lw back
    imem_m[17] = it_i(6'd43, 6, 3, -4);       // negative offset
    imem_m[18] = it_i(6'd4, 2, 3, 5);         // beq not taken
    imem_m[19] = it_i(6'd4, 14, 5, 2);        // beq taken -> 22
    imem_m[20] = rt_i(2, 2, 15, 6'h20);
    imem_m[21] = rt_i(3, 3, 15, 6'h20);
    imem_m[22] = {6'h3F, 26'h3FF_FFFF};       // unknown opcode
    imem_m[23] = rt_i(2, 3, 16, 6'h00);       // unknown funct
    imem_m[24] = it_i(6'd35, 0, 17, 20);      // counter = 3
    imem_m[25] = it_i(6'd35, 0, 18, 24);      // step = 1
    imem_m[26] = rt_i(17, 18, 17, 6'h22);
    imem_m[27] = it_i(6'd4, 17, 0, 1);
    imem_m[28] = jt_i(26);
    imem_m[29] = it_i(6'd35, 0, 19, 4);
    imem_m[30] = it_i(6'd4, 0, 0, -1);        // halt loop

    // R10: fill both arrays through the load port while reset is held
    for (int i = 0; i < 2 * DEPTH; i++) begin
      @(negedge clk);
      ld_we   = 1'b1;
      ld_dmem = (i >= DEPTH);
      ld_addr = MEM_AW'(i % DEPTH);
      ld_data = (i >= DEPTH) ? dmem_m[i - DEPTH] : imem_m[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);
    rst = 1'b0;
    pc_m = '0;
    prev_tag = "R1";
    chk(rf_wdata_o == 32'd0, "R11", "cleared reg sum", rf_wdata_o, 32'd0);

    for (int cyc = 0; cyc < 70; cyc++) begin
      logic [31:0] ins, nxt, ewd, eaddr, eswd, a, b;
      logic [5:0] op, fn;
      logic ewe, edw;
      logic [4:0] ewa;
      string tag;
      chk(pc_o == pc_m, prev_tag, "pc", pc_o, pc_m);
      ins = imem_m[pc_m[MEM_AW+1:2]];
      chk(ir_o == ins, "R10", "fetched word", ir_o, ins);
      op = ins[31:26]; fn = ins[5:0];
      a = regs_m[ins[25:21]]; b = regs_m[ins[20:16]];
      ewe = 1'b0; edw = 1'b0; ewa = '0; ewd = '0; eaddr = '0; eswd = '0;
      nxt = pc_m + 4; tag = "R9";
      if (op == 6'd0) begin
        ewa = ins[15:11]; ewe = 1'b1; tag = "R2";
        case (fn)
          6'h20: ewd = a + b;
          6'h22: ewd = a - b;
          6'h24: ewd = a & b;
          6'h25: ewd = a | b;
          6'h2A: begin ewd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
          default: begin ewe = 1'b0; tag = "R9"; end
        endcase
      end else if (op == 6'd35) begin
        eaddr = a + {{16{ins[15]}}, ins[15:0]};
        ewa = ins[20:16]; ewe = 1'b1; ewd = dmem_m[eaddr[MEM_AW+1:2]]; tag = "R4";
      end else if (op == 6'd43) begin
        eaddr = a + {{16{ins[15]}}, ins[15:0]};
        edw = 1'b1; eswd = b; tag = (ins[20:16] == 0) ? "R8" : "R5";
      end else if (op == 6'd4) begin
        tag = "R6";
        if (a == b) nxt = pc_m + 4 + {{14{ins[15]}}, ins[15:0], 2'b00};
      end else if (op == 6'd2) begin
        tag = "R7";
        nxt = {pc_m[31:28], ins[25:0], 2'b00};
      end
      if (ewe && ewa == 0) tag = "R8";
      chk(rf_we_o == ewe, tag, "reg write enable", 32'(rf_we_o), 32'(ewe));
      if (ewe) begin
        chk(rf_waddr_o == ewa, tag, "reg write index", 32'(rf_waddr_o), 32'(ewa));
        chk(rf_wdata_o == ewd, tag, "reg write value", rf_wdata_o, ewd);
      end
      chk(dm_we_o == edw, tag, "store enable", 32'(dm_we_o), 32'(edw));
      if (edw) begin
        chk(dm_addr_o == eaddr, tag, "store address", dm_addr_o, eaddr);
        chk(dm_wdata_o == eswd, tag, "store data", dm_wdata_o, eswd);
      end
      if (ewe && ewa != 0) regs_m[ewa] = ewd;
      if (edw) dmem_m[eaddr[MEM_AW+1:2]] = eswd;
      pc_m = nxt;
      prev_tag = (tag == "R8" || tag == "R2" || tag == "R3" || tag == "R4" ||
                  tag == "R5" || tag == "R9") ? "R1" : tag;
      @(negedge clk);
    end
    chk(pc_o == 32'd120, "R6", "halt loop holds", pc_o, 32'd120);
    finish_run();
  end
endmodule